// File: doc/BRIEF.md
# Thermometer-to-Binary Flash Encoder

This block sits behind the comparator bank of a parallel (flash) converter and turns the raw comparator bits into a binary sample code. There is one comparator bit per reference tap, with bit 0 at the lowest tap. A rising analog input turns the bits on from the bottom up, so a clean input is a thermometer code. The code the block reports is the index of the highest comparator that is high.

The transition point is found by taking the exclusive-OR of each bit with the bit one position above it. On a clean thermometer code this gives exactly one hot line. A guard stage keeps only the uppermost hot line, and a plain OR-matrix encoder then turns that line into binary. No priority encoder sits in the data path. The comparator bits are registered on the sample clock, and the encoded result is registered one clock later. The result comes with a valid flag, an overflow flag for a full-scale input, and a bubble flag for a pattern that is not a thermometer code.

Top module: `flash_therm_enc`

## Requirements
- R1: `cmp_i` has 2^OUT_W bits, one per reference tap. Bit k belongs to tap k, with bit 0 the lowest tap. The default OUT_W=3 gives 8 bits.
- R2: For a thermometer input (bits 0..m high, all others low), `code_o` equals m, the index of the highest high bit.
- R3: When every bit of `cmp_i` is low, `code_o` is 0. `ovf_o` and `bubble_o` are also 0.
- R4: A value on `cmp_i` at rising edge k is reported on the outputs after rising edge k+1. `valid_o` is low until the first sample taken after reset reaches the outputs, and it then stays high until the next reset.
- R5: When the top bit of the sample is high, `code_o` is all ones and `ovf_o` is 1 for that sample. Otherwise `ovf_o` is 0.
- R6: For any pattern, `code_o` equals the index of the highest high bit. `bubble_o` is 1 exactly when some bit is high above a bit that is low (the pattern is not a thermometer code).
- R7: While `rst_ni` is low, `code_o`, `valid_o`, `ovf_o` and `bubble_o` are all 0, including in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 2^OUT_W | Comparator bits, bit 0 = lowest tap |
| code_o | output | OUT_W | Index of highest active comparator |
| valid_o | output | 1 | Output holds a real sample |
| ovf_o | output | 1 | Top comparator was high for this sample |
| bubble_o | output | 1 | Sample was not a thermometer code |

## Verification
Most internal faults appear on `code_o` within two edges of the sample that exposes them. A swapped or dropped OR term in the encoder shows as a wrong code for every level whose index has that bit set. A broken exclusive-OR neighbour shows as a false `bubble_o` on clean thermometer inputs. If the guard stage fails, the code is corrupted only on bubbled patterns, so random non-thermometer inputs are mixed with directed levels. A pipeline or valid fault shows as a one-cycle shift between stimulus and result, or as `valid_o` rising too early after reset.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;
  parameter int unsigned FLASH_OUT_W = 3;

  typedef struct packed {
    logic ovf;
    logic bubble;
  } flash_flags_t;
endpackage

// File: rtl/therm_edge_detect.sv
module therm_edge_detect #(
  parameter int unsigned NUM_TAPS = 8
) (
  input  logic [NUM_TAPS-1:0] therm_i,
  output logic [NUM_TAPS-1:0] hot_o
);
  // line k marks tap k as the last high one before a low neighbour above
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_edge
    if (k == NUM_TAPS - 1) begin : g_top
      assign hot_o[k] = therm_i[k];
    end else begin : g_mid
      assign hot_o[k] = therm_i[k] ^ therm_i[k+1];
    end
  end
endmodule

// File: rtl/hot_top_select.sv
module hot_top_select #(
  parameter int unsigned NUM_TAPS = 8
) (
  input  logic [NUM_TAPS-1:0] hot_i,
  output logic [NUM_TAPS-1:0] sel_o,
  output logic                multi_o
);
  logic [NUM_TAPS-1:0] above;

  // above[k]: any hot line strictly above k
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_chain
    if (k == NUM_TAPS - 1) begin : g_top
      assign above[k] = 1'b0;
    end else begin : g_mid
      assign above[k] = above[k+1] | hot_i[k+1];
    end
  end

  assign sel_o   = hot_i & ~above;
  assign multi_o = |(hot_i & above);
endmodule

// File: rtl/onehot_or_encoder.sv
module onehot_or_encoder #(
  parameter int unsigned OUT_W    = 3,
  parameter int unsigned NUM_TAPS = 1 << OUT_W
) (
  input  logic [NUM_TAPS-1:0] onehot_i,
  output logic [OUT_W-1:0]    code_o
);
  for (genvar j = 0; j < OUT_W; j++) begin : g_bit
    always_comb begin
      code_o[j] = 1'b0;
      for (int k = 0; k < NUM_TAPS; k++) begin
        if (((k >> j) & 1) != 0) code_o[j] = code_o[j] | onehot_i[k];
      end
    end
  end
endmodule

// File: rtl/flash_therm_enc.sv
module flash_therm_enc
  import flash_enc_pkg::*;
#(
  parameter int unsigned OUT_W = FLASH_OUT_W,
  localparam int unsigned NUM_TAPS = 1 << OUT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TAPS-1:0] cmp_i,
  output logic [OUT_W-1:0]    code_o,
  output logic                valid_o,
  output logic                ovf_o,
  output logic                bubble_o
);
  logic [NUM_TAPS-1:0] cmp_q;
  logic                cap_q;
  logic [NUM_TAPS-1:0] hot;
  logic [NUM_TAPS-1:0] sel;
  logic                multi;
  logic [OUT_W-1:0]    code_d;
  flash_flags_t        flags_d, flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      cap_q <= 1'b0;
    end else begin
      cmp_q <= cmp_i;
      cap_q <= 1'b1;
    end
  end

  therm_edge_detect #(.NUM_TAPS(NUM_TAPS)) u_edge (
    .therm_i (cmp_q),
    .hot_o   (hot)
  );

  hot_top_select #(.NUM_TAPS(NUM_TAPS)) u_sel (
    .hot_i   (hot),
    .sel_o   (sel),
    .multi_o (multi)
  );

  onehot_or_encoder #(.OUT_W(OUT_W), .NUM_TAPS(NUM_TAPS)) u_enc (
    .onehot_i (sel),
    .code_o   (code_d)
  );

  assign flags_d.ovf    = cmp_q[NUM_TAPS-1];
  assign flags_d.bubble = multi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o  <= '0;
      valid_o <= 1'b0;
      flags_q <= '0;
    end else begin
      code_o  <= code_d;
      valid_o <= cap_q;
      flags_q <= flags_d;
    end
  end

  assign ovf_o    = flags_q.ovf;
  assign bubble_o = flags_q.bubble;
endmodule

// File: rtl/flash_therm_enc_chk.sv
module flash_therm_enc_chk #(
  parameter int unsigned OUT_W = 3,
  localparam int unsigned NUM_TAPS = 1 << OUT_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_TAPS-1:0] cmp_i,
  input logic [OUT_W-1:0]    code_o,
  input logic                valid_o,
  input logic                ovf_o,
  input logic                bubble_o
);
  function automatic logic [OUT_W-1:0] top_idx(input logic [NUM_TAPS-1:0] v);
    top_idx = '0;
    for (int k = 0; k < NUM_TAPS; k++) if (v[k]) top_idx = OUT_W'(k);
  endfunction

  function automatic logic is_thermo(input logic [NUM_TAPS-1:0] v);
    is_thermo = 1'b1;
    for (int k = 0; k < NUM_TAPS - 1; k++) if (!v[k] && v[k+1]) is_thermo = 1'b0;
  endfunction

  AST_CODE_TRACKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> code_o == top_idx($past(cmp_i, 2)));  // R6

  AST_OVF_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> code_o == {OUT_W{1'b1}});  // R5

  AST_OVF_FROM_TOP_TAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ovf_o == $past(cmp_i[NUM_TAPS-1], 2));  // R5

  AST_BUBBLE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> bubble_o == !is_thermo($past(cmp_i, 2)));  // R6

  AST_VALID_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);  // R4

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (code_o == '0 && !ovf_o && !bubble_o));  // R4

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (code_o == '0 && !valid_o && !ovf_o && !bubble_o));  // R7
endmodule

bind flash_therm_enc flash_therm_enc_chk #(.OUT_W(OUT_W)) u_chk (.*);

// File: tb/tb_flash_therm_enc.sv
module tb_flash_therm_enc;
  localparam int unsigned OUT_W = 3;
  localparam int unsigned NT    = 1 << OUT_W;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [NT-1:0] cmp_i;
  logic [OUT_W-1:0] code_o;
  logic          valid_o, ovf_o, bubble_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [NT-1:0] h_v [2];
  string         h_r [2];
  int            n_hist;

  always #4 clk_i = ~clk_i;

  flash_therm_enc #(.OUT_W(OUT_W)) dut (.*);

  function automatic logic [OUT_W-1:0] ref_code(input logic [NT-1:0] v);
    ref_code = '0;
    for (int k = 0; k < NT; k++) if (v[k]) ref_code = OUT_W'(k);
  endfunction

  function automatic logic ref_bubble(input logic [NT-1:0] v);
    ref_bubble = 1'b0;
    for (int k = 0; k < NT - 1; k++) if (!v[k] && v[k+1]) ref_bubble = 1'b1;
  endfunction

  function automatic logic [NT-1:0] therm(input int lvl);
    logic [NT:0] t;
    t = (NT+1)'((64'd1 << lvl) - 1);
    therm = t[NT-1:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_out(input logic [NT-1:0] v, input string req);
    chk(req, 32'(code_o), 32'(ref_code(v)));
    chk("R4 valid", 32'(valid_o), 32'd1);
    chk("R5 ovf", 32'(ovf_o), 32'(v[NT-1]));
    chk("R6 bubble", 32'(bubble_o), 32'(ref_bubble(v)));
  endtask

  task automatic step(input logic [NT-1:0] v, input string req);
    @(negedge clk_i);
    if (n_hist >= 2) check_out(h_v[1], h_r[1]);
    else begin
      chk("R4 valid low before first result", 32'(valid_o), 32'd0);
      chk("R4 code idle", 32'(code_o), 32'd0);
    end
    h_v[1] = h_v[0]; h_r[1] = h_r[0];
    h_v[0] = v;      h_r[0] = req;
    n_hist++;
    cmp_i = v;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    cmp_i  = '1;
    #1;
    chk("R7 code in reset", 32'(code_o), 32'd0);
    chk("R7 valid in reset", 32'(valid_o), 32'd0);
    chk("R7 ovf in reset", 32'(ovf_o), 32'd0);
    chk("R7 bubble in reset", 32'(bubble_o), 32'd0);
    repeat (2) @(negedge clk_i);
    chk("R7 code held in reset", 32'(code_o), 32'd0);
    cmp_i  = '0;
    rst_ni = 1'b1;
    h_v[0] = '0; h_r[0] = "R3";
    n_hist = 1;
  endtask

  initial begin
    rst_ni = 1'b0;
    cmp_i  = '0;
    void'($urandom(32'h5eed_1234));
    do_reset();
    step('0, "R3");
    step('0, "R3");
    for (int l = 0; l <= NT; l++) step(therm(l), "R2");
    for (int l = NT; l >= 0; l--) step(therm(l), "R2");
    step('1, "R5");
    step(8'b1000_0000, "R6");
    step(8'b0000_0010, "R6");
    step(8'b0101_0101, "R6");
    step(8'b0011_1011, "R6");
    step('0, "R3");
    step(8'b0000_0001, "R1");
    step(8'b0000_0011, "R1");
    do_reset();
    for (int i = 0; i < 400; i++) begin
      if (i % 2 == 0) step(therm(int'($urandom_range(NT, 0))), "R2");
      else            step(NT'($urandom), "R6");
    end
    step('0, "R3");
    step('0, "R3");
    step('0, "R3");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule